// File: doc/BRIEF.md
# Wake-Up Fast Restart Controller

This block brings a chip out of its low-power wait state quickly when an external wake line is pulled low. Sixteen active-low wake lines arrive at the block. A 16-bit enable mask, written by software, chooses which of them may start a restart. A combinational detector raises a single restart request as soon as any enabled line is low. The request passes through a small synchroniser into the clock-management domain.

When the chip is in wait mode, the synchronised request starts a three-step recovery sequencer. First it forces the internal fast RC oscillator on. It waits for the oscillator to report that it is stable, and only then steers the master clock onto that fast source. One cycle later it ungates the processor clock. The three force outputs stay asserted until the power manager leaves wait mode. The block keeps no record of which line caused the wake-up; software reads the pin levels itself.

The oscillator and the I/O pins lie outside this block. They appear only as the ready input and the wake lines.

Top module: `wake_restart_ctrl`

## Requirements
- R1: While rst_n is sampled low on a rising edge, the enable mask is cleared to 0 and osc_on_o, mclk_fast_o and cpu_clk_en_o are all 0 after that edge.
- R2: A rising edge with mask_wr_i high loads mask_data_i into the enable mask, which mask_o shows. Mask bit i enables wake line i.
- R3: restart_req_o is a combinational output. It is 1 exactly when some line i has wake_n_i[i] = 0 and mask bit i = 1, with no clock edge in between.
- R4: A low level on a line whose mask bit is 0 has no effect: restart_req_o stays 0 and osc_on_o stays 0.
- R5: When wait_mode_i is 0 and the sequencer is idle, a restart request is ignored and osc_on_o stays 0.
- R6: With wait_mode_i high, osc_on_o rises on the third rising edge after restart_req_o goes high: two synchroniser flops, then the sequencer state register. It is still 0 after the second edge.
- R7: mclk_fast_o rises only on a rising edge at which osc_ready_i is sampled high while osc_on_o is already 1. While osc_ready_i stays low, mclk_fast_o stays 0.
- R8: cpu_clk_en_o rises on the rising edge after mclk_fast_o rises.
- R9: Once all three outputs are 1, they stay 1 while wait_mode_i is high, even if every wake line returns high. On the first edge that samples wait_mode_i low, all three return to 0.
- R10: A started sequence runs to completion even if the restart request is withdrawn before osc_ready_i arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock-management domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mask_wr_i | input | 1 | Write strobe for the enable mask |
| mask_data_i | input | 16 | New enable mask value |
| mask_o | output | 16 | Current enable mask |
| wake_n_i | input | 16 | Active-low wake lines, asynchronous |
| wait_mode_i | input | 1 | High while the chip is in wait mode |
| osc_ready_i | input | 1 | Fast RC oscillator reports stable output |
| restart_req_o | output | 1 | Combinational restart request |
| osc_on_o | output | 1 | Force the fast RC oscillator on |
| mclk_fast_o | output | 1 | Select the fast RC clock as master clock |
| cpu_clk_en_o | output | 1 | Force the processor clock enabled |

## Verification
Every cycle, assertions check the ordering of the recovery outputs. The master clock never moves to the fast source before oscillator-ready is seen, the processor clock is ungated only after the clock switch, and the outputs are held while wait mode lasts. They also check that an idle sequencer stays idle outside wait mode, and that reset clears the mask. The masking rules only show up in the bench's scenarios: the exact combinational request for each mask and pin pattern, the three-edge latency, and the run to completion after the request is withdrawn.

// File: rtl/fr_pkg.sv
// Package: shared types for the wake-up fast restart controller.
// Assumes: a single clock domain for the sequencer; wake lines are asynchronous.
package fr_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_OSC    = 2'd1,
        SEQ_SWITCH = 2'd2,
        SEQ_CPU    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fr_mask_reg.sv
// Enable mask register: holds one enable bit per wake line.
// Assumes: synchronous active-low reset clears every bit, so nothing wakes before setup.
module fr_mask_reg #(
    parameter int N_LINES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [N_LINES-1:0] data_i,
    output logic [N_LINES-1:0] mask_o
);
    logic [N_LINES-1:0] mask_q;

    // Load the mask on a write strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= data_i;
    end

    assign mask_o = mask_q;

    // R1
    mask_reset_chk: assert property (@(posedge clk) !rst_n |=> mask_q == '0);
endmodule

// File: rtl/fr_detect.sv
// Wake detector: asynchronous OR of the enabled, inverted wake lines.
// Assumes: wake lines are active low; no clock is involved on this path.
module fr_detect #(
    parameter int N_LINES = 16
) (
    input  logic [N_LINES-1:0] wake_n_i,
    input  logic [N_LINES-1:0] mask_i,
    output logic               req_o
);
    logic [N_LINES-1:0] hit;

    // One qualified hit per line.
    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            assign hit[gi] = mask_i[gi] & ~wake_n_i[gi];
        end
    endgenerate

    // Collapse all hits into the single request.
    always_comb req_o = |hit;
endmodule

// File: rtl/fr_sync.sv
// Level synchroniser: carries an asynchronous level into the clk domain.
// Assumes: STAGES >= 2; reset drives every stage to 0.
module fr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fr_seq.sv
// Recovery sequencer: oscillator on, wait ready, switch master clock, ungate CPU.
// Assumes: req_i is already synchronous; outputs decode from the state register
// so they are glitch-free; leaving wait mode is the only exit from the last step.
module fr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic wait_mode_i,
    input  logic osc_ready_i,
    output logic osc_on_o,
    output logic mclk_fast_o,
    output logic cpu_clk_en_o
);
    import fr_pkg::*;

    seq_state_t st_q, st_d;

    // Next-state selection for the three-step recovery.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   if (req_i && wait_mode_i) st_d = SEQ_OSC;
            SEQ_OSC:    if (osc_ready_i)          st_d = SEQ_SWITCH;
            SEQ_SWITCH:                           st_d = SEQ_CPU;
            SEQ_CPU:    if (!wait_mode_i)         st_d = SEQ_IDLE;
            default:                              st_d = SEQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= SEQ_IDLE;
        else
            st_q <= st_d;
    end

    // Moore decode of the force outputs.
    always_comb begin
        osc_on_o     = (st_q != SEQ_IDLE);
        mclk_fast_o  = (st_q == SEQ_SWITCH) || (st_q == SEQ_CPU);
        cpu_clk_en_o = (st_q == SEQ_CPU);
    end

    // R5
    run_mode_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_IDLE && !wait_mode_i) |=> !osc_on_o);
    // R7
    no_runt_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_fast_o) |-> ($past(osc_ready_i) && $past(osc_on_o)));
    // R7
    mclk_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_fast_o |-> osc_on_o);
    // R8
    cpu_after_mclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en_o) |-> $past(mclk_fast_o));
    // R9
    hold_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en_o && wait_mode_i) |=> (cpu_clk_en_o && mclk_fast_o && osc_on_o));
endmodule

// File: rtl/wake_restart_ctrl.sv
// Top: wake-up fast restart controller.
// Assumes: wake_n_i is asynchronous and active low; osc_ready_i comes from the
// fast RC oscillator; the three force outputs are ORed into clock management.
module wake_restart_ctrl #(
    parameter int N_LINES     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr_i,
    input  logic [N_LINES-1:0] mask_data_i,
    output logic [N_LINES-1:0] mask_o,
    input  logic [N_LINES-1:0] wake_n_i,
    input  logic               wait_mode_i,
    input  logic               osc_ready_i,
    output logic               restart_req_o,
    output logic               osc_on_o,
    output logic               mclk_fast_o,
    output logic               cpu_clk_en_o
);
    logic [N_LINES-1:0] mask_w;
    logic               req_async;
    logic               req_sync;

    fr_mask_reg #(.N_LINES(N_LINES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mask_wr_i),
        .data_i (mask_data_i),
        .mask_o (mask_w)
    );

    fr_detect #(.N_LINES(N_LINES)) u_detect (
        .wake_n_i (wake_n_i),
        .mask_i   (mask_w),
        .req_o    (req_async)
    );

    fr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_async),
        .q_o   (req_sync)
    );

    fr_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_sync),
        .wait_mode_i  (wait_mode_i),
        .osc_ready_i  (osc_ready_i),
        .osc_on_o     (osc_on_o),
        .mclk_fast_o  (mclk_fast_o),
        .cpu_clk_en_o (cpu_clk_en_o)
    );

    assign mask_o        = mask_w;
    assign restart_req_o = req_async;
endmodule

// File: tb/tb_wake_restart_ctrl.sv
module tb_wake_restart_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mask_wr_i;
    logic [15:0] mask_data_i;
    logic [15:0] mask_o;
    logic [15:0] wake_n_i;
    logic        wait_mode_i;
    logic        osc_ready_i;
    logic        restart_req_o;
    logic        osc_on_o;
    logic        mclk_fast_o;
    logic        cpu_clk_en_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wake_restart_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
        .mask_o(mask_o), .wake_n_i(wake_n_i), .wait_mode_i(wait_mode_i),
        .osc_ready_i(osc_ready_i), .restart_req_o(restart_req_o), .osc_on_o(osc_on_o),
        .mclk_fast_o(mclk_fast_o), .cpu_clk_en_o(cpu_clk_en_o)
    );

    // {mask, wake_n, wait, expected request, expected osc_on after 3 edges}
    localparam logic [34:0] VEC [8] = '{
        {16'h0001, 16'hFFFE, 1'b1, 1'b1, 1'b1},
        {16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0},
        {16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1},
        {16'h8000, 16'h8000, 1'b1, 1'b0, 1'b0},
        {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0},
        {16'h00F0, 16'hFFDF, 1'b0, 1'b1, 1'b0},
        {16'hA5A5, 16'hFFFB, 1'b1, 1'b1, 1'b1},
        {16'h5A5A, 16'hFFFB, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic write_mask(input logic [15:0] m);
        @(negedge clk);
        mask_wr_i   = 1'b1;
        mask_data_i = m;
        @(negedge clk);
        mask_wr_i   = 1'b0;
    endtask

    task automatic to_idle();
        wake_n_i    = 16'hFFFF;
        wait_mode_i = 1'b0;
        osc_ready_i = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        osc_ready_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; mask_wr_i = 1'b0; mask_data_i = '0;
        wake_n_i = 16'hFFFF; wait_mode_i = 1'b0; osc_ready_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 mask", mask_o, 0);
        check("R1 forces", {osc_on_o, mclk_fast_o, cpu_clk_en_o}, 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            write_mask(VEC[i][34:19]);
            check("R2 mask readback", mask_o, VEC[i][34:19]);
            wake_n_i    = VEC[i][18:3];
            wait_mode_i = VEC[i][2];
            #1;
            check("R3/R4 request", restart_req_o, VEC[i][1]);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R4/R5/R6 osc_on", osc_on_o, VEC[i][0]);
            to_idle();
        end

        // R6 exact latency, R7 wait for ready, R8, R9, R10
        write_mask(16'h0010);
        wait_mode_i = 1'b1;
        wake_n_i    = 16'hFFEF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R6 not yet after 2 edges", osc_on_o, 0);
        @(posedge clk);
        @(negedge clk);
        check("R6 on after 3 edges", osc_on_o, 1);
        wake_n_i = 16'hFFFF;            // R10 withdraw request
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R7 no switch without ready", {osc_on_o, mclk_fast_o}, 2'b10);
        osc_ready_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 switch on ready", {mclk_fast_o, cpu_clk_en_o}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        check("R8 cpu one edge later", cpu_clk_en_o, 1);
        check("R10 completed after withdraw", {osc_on_o, mclk_fast_o, cpu_clk_en_o}, 3'b111);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9 held in wait", {osc_on_o, mclk_fast_o, cpu_clk_en_o}, 3'b111);
        wait_mode_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 released", {osc_on_o, mclk_fast_o, cpu_clk_en_o}, 3'b000);
        osc_ready_i = 1'b0;

        // R1 reset during an active sequence
        wait_mode_i = 1'b1;
        wake_n_i    = 16'hFFEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 restart again", osc_on_o, 1);
        rst_n    = 1'b0;
        wake_n_i = 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        check("R1 mask cleared mid-run", mask_o, 0);
        check("R1 forces cleared mid-run", {osc_on_o, mclk_fast_o, cpu_clk_en_o}, 0);
        rst_n    = 1'b1;
        wake_n_i = 16'h0000;
        #1;
        check("R4 cleared mask blocks all", restart_req_o, 0);

        done = 1'b1;
        finish_run();
    end
endmodule